// File: doc/BRIEF.md
# Indexed Configuration Register Port Controller

This block sits on the processor side of a 16-bit I/O address space and decides, for every port access, whether the access is absorbed by a small on-chip configuration register file or forwarded as an external I/O cycle. Software reaches a configuration register in two steps. It first writes the register number to the index port at 22h. It then reads or writes the value through the data port at 23h. The index is single-use: once one data access has been served on chip, software must write the index again before the next data access.

The access bus presents a dword address (`io_addr`, bits 15 down to 2), four byte enables, one-cycle read and write strobes that never occur together, write data, and read data. Every output is combinational and valid in the same cycle as the strobe. The controller raises `ext_req` for every access that goes external, and for external reads it forwards `ext_rdata` to `io_rdata`. A separate one-cycle `smi_trap` output flags any access that touches the display-adapter window 3B0h to 3DFh, but only while the trap-enable configuration bit is set. Such an access still goes external.

Arming is a two-state machine. `ST_IDLE` means no index is held. `ST_ARMED` means a valid index is latched. The machine has four named transitions:
- *arm* (`ST_IDLE` to `ST_ARMED`) on a valid index write.
- *rearm* (`ST_ARMED` to `ST_ARMED`) on a further valid index write, which replaces the held index.
- *consume* (`ST_ARMED` to `ST_IDLE`) on any read or write of the data port.
- *reject* (`ST_ARMED` to `ST_IDLE`) on an index write with an invalid value.

Any other access leaves the state unchanged.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The controller handles an access on chip only in two cases. The first is a dword address of 20h>>2 with byte enables exactly 0100b, which is the index port 22h with its data in bits 23:16. The second is the same dword address with byte enables exactly 1000b, which is the data port 23h with its data in bits 31:24. Any access with other byte enables, including 16-bit and 32-bit accesses covering these ports, goes external in full and changes no on-chip state.
- R2: A write to the index port with a value in C0h–CFh or FEh–FFh is absorbed (`ext_req` low), latches the index and enters `ST_ARMED`.
- R3: A write to the index port with any other value goes external, leaves every configuration register unchanged and returns the machine to `ST_IDLE`.
- R4: A read of the index port always goes external and does not change the arming state.
- R5: A data-port write in `ST_ARMED` stores bits 31:24 into the register selected by the held index and does not raise `ext_req`.
- R6: A data-port read in `ST_ARMED` does not raise `ext_req`. It returns the selected register in bits 31:24 of `io_rdata`, with all other bits zero.
- R7: A data-port access in `ST_IDLE` goes external and leaves every configuration register unchanged.
- R8: Any data-port read or write served on chip returns the machine to `ST_IDLE`, so an immediately following data-port access goes external.
- R9: `ext_req` is high exactly in the cycle of a strobe that is not handled on chip. In that cycle a read returns `ext_rdata` unchanged. With no strobe, `ext_req` and `smi_trap` are low and `io_rdata` is zero.
- R10: After a synchronous active-low reset, all 18 registers read back as 00h and the machine is in `ST_IDLE`.
- R11: With bit 0 of the register at index C1h set, any strobe whose enabled byte lanes touch an address in 3B0h–3DFh raises `smi_trap` for that cycle only and is still forwarded externally. With the bit clear, no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 14 | Dword address, I/O address bits 15:2 |
| io_be | input | 4 | Byte enables, bit n selects bits 8n+7:8n |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for the current read strobe |
| ext_rdata | input | 32 | Read data returned by the external cycle |
| ext_req | output | 1 | Access is forwarded as an external I/O cycle |
| smi_trap | output | 1 | One-cycle trap request for the display window |

## Verification
A wrong arming state shows up at the very next data-port access. A stuck-armed machine absorbs an access that should raise `ext_req`, and a stuck-idle machine forwards one that should stay on chip, so the error surfaces within one strobe. A wrong latched index or a corrupted register stays hidden until that register is read back through the data port, so the bench reads back all 18 registers after each group of writes. A wrong trap-enable bit is visible at `smi_trap` in the first cycle that touches the display window.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    // valid index ranges: one run of sixteen and one run of two
    localparam logic [7:0] IDX_LO_BASE = 8'hC0;
    localparam int         IDX_LO_CNT  = 16;
    localparam logic [7:0] IDX_HI_BASE = 8'hFE;
    localparam int         IDX_HI_CNT  = 2;
    localparam int         NUM_REGS    = IDX_LO_CNT + IDX_HI_CNT;
    localparam int         SLOT_W      = $clog2(NUM_REGS);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

    function automatic logic idx_valid(input logic [7:0] v);
        logic lo_hit;
        logic hi_hit;
        lo_hit = (int'(v) >= int'(IDX_LO_BASE)) &&
                 (int'(v) <  int'(IDX_LO_BASE) + IDX_LO_CNT);
        hi_hit = (int'(v) >= int'(IDX_HI_BASE)) &&
                 (int'(v) <  int'(IDX_HI_BASE) + IDX_HI_CNT);
        return lo_hit || hi_hit;
    endfunction

    // maps a valid index to a dense register number
    function automatic logic [SLOT_W-1:0] idx_slot(input logic [7:0] v);
        if (int'(v) < int'(IDX_LO_BASE) + IDX_LO_CNT)
            return SLOT_W'(int'(v) - int'(IDX_LO_BASE));
        else
            return SLOT_W'(IDX_LO_CNT + int'(v) - int'(IDX_HI_BASE));
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              LANES     = 4,
    parameter int              LB        = 2,
    parameter logic [15:0]     IDX_PORT  = 16'h0022,
    parameter logic [15:0]     DATA_PORT = 16'h0023,
    parameter logic [15:0]     TRAP_LO   = 16'h03B0,
    parameter logic [15:0]     TRAP_HI   = 16'h03DF
) (
    input  logic [ADDR_W-1:LB]  addr,
    input  logic [LANES-1:0]    be,
    input  logic [LANES*8-1:0]  wdata,
    output logic                at_idx,
    output logic                at_data,
    output logic [7:0]          idx_byte,
    output logic                win_hit
);
    localparam int IDX_LANE  = int'(IDX_PORT[LB-1:0]);
    localparam int DATA_LANE = int'(DATA_PORT[LB-1:0]);
    localparam logic [ADDR_W-1:LB] IDX_DW  = IDX_PORT[ADDR_W-1:LB];
    localparam logic [ADDR_W-1:LB] DATA_DW = DATA_PORT[ADDR_W-1:LB];
    localparam logic [LANES-1:0] IDX_BE  = LANES'(1) << IDX_LANE;
    localparam logic [LANES-1:0] DATA_BE = LANES'(1) << DATA_LANE;

    logic [LANES-1:0] lane_hit;

    // only an exact single-byte access on the port lane is a candidate
    assign at_idx   = (addr == IDX_DW)  && (be == IDX_BE);
    assign at_data  = (addr == DATA_DW) && (be == DATA_BE);
    assign idx_byte = wdata[IDX_LANE*8 +: 8];

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [ADDR_W-1:0] byte_addr;
            assign byte_addr   = {addr, LB'(l)};
            assign lane_hit[l] = be[l] &&
                                 (byte_addr >= TRAP_LO[ADDR_W-1:0]) &&
                                 (byte_addr <= TRAP_HI[ADDR_W-1:0]);
        end
    endgenerate

    assign win_hit = |lane_hit;

endmodule

// File: rtl/cfg_port_arm.sv
module cfg_port_arm
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [7:0]        idx_byte,
    input  logic              data_acc,
    output logic              armed,
    output logic [SLOT_W-1:0] slot,
    output logic              idx_take,
    output logic              data_take
);
    arm_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              good_idx;

    assign good_idx = idx_wr && idx_valid(idx_byte);

    // state register and held index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (good_idx)
                slot_q <= idx_slot(idx_byte);
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        idx_take  = good_idx;
        data_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (good_idx)
                    state_d = ST_ARMED;              // arm
            end
            ST_ARMED: begin
                if (good_idx)
                    state_d = ST_ARMED;              // rearm
                else if (idx_wr)
                    state_d = ST_IDLE;               // reject
                else if (data_acc) begin
                    state_d   = ST_IDLE;             // consume
                    data_take = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign armed = (state_q == ST_ARMED);
    assign slot  = slot_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int NUM_REGS = 18,
    parameter int SLOT_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SLOT_W-1:0]     slot,
    input  logic [7:0]            wbyte,
    output logic [NUM_REGS*8-1:0] flat
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 8'h00;
                else if (we && (slot == SLOT_W'(g)))
                    q <= wbyte;
            end
            assign flat[g*8 +: 8] = q;
        end
    endgenerate

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 32,
    parameter logic [15:0] IDX_PORT    = 16'h0022,
    parameter logic [15:0] DATA_PORT   = 16'h0023,
    parameter logic [15:0] TRAP_LO     = 16'h03B0,
    parameter logic [15:0] TRAP_HI     = 16'h03DF,
    parameter logic [7:0]  TRAP_EN_IDX = 8'hC1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ADDR_W-1:$clog2(DATA_W/8)]      io_addr,
    input  logic [DATA_W/8-1:0]                   io_be,
    input  logic                                  io_rd,
    input  logic                                  io_wr,
    input  logic [DATA_W-1:0]                     io_wdata,
    output logic [DATA_W-1:0]                     io_rdata,
    input  logic [DATA_W-1:0]                     ext_rdata,
    output logic                                  ext_req,
    output logic                                  smi_trap
);
    localparam int LANES     = DATA_W / 8;
    localparam int LB        = $clog2(LANES);
    localparam int DATA_LANE = int'(DATA_PORT[LB-1:0]);
    localparam int TRAP_SLOT = int'(idx_slot(TRAP_EN_IDX));

    logic                  strobe;
    logic                  at_idx, at_data, win_hit;
    logic [7:0]            idx_byte;
    logic                  armed;
    logic [SLOT_W-1:0]     slot;
    logic                  idx_take, data_take, onchip;
    logic [NUM_REGS*8-1:0] regs_flat;
    logic [7:0]            sel_byte;
    logic                  trap_en;

    assign strobe = io_rd || io_wr;

    cfg_port_decode #(
        .ADDR_W   (ADDR_W),
        .LANES    (LANES),
        .LB       (LB),
        .IDX_PORT (IDX_PORT),
        .DATA_PORT(DATA_PORT),
        .TRAP_LO  (TRAP_LO),
        .TRAP_HI  (TRAP_HI)
    ) u_dec (
        .addr    (io_addr),
        .be      (io_be),
        .wdata   (io_wdata),
        .at_idx  (at_idx),
        .at_data (at_data),
        .idx_byte(idx_byte),
        .win_hit (win_hit)
    );

    cfg_port_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && at_idx),
        .idx_byte (idx_byte),
        .data_acc (strobe && at_data),
        .armed    (armed),
        .slot     (slot),
        .idx_take (idx_take),
        .data_take(data_take)
    );

    cfg_regfile #(
        .NUM_REGS(NUM_REGS),
        .SLOT_W  (SLOT_W)
    ) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (io_wr && data_take),
        .slot (slot),
        .wbyte(io_wdata[DATA_LANE*8 +: 8]),
        .flat (regs_flat)
    );

    always_comb begin
        sel_byte = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (slot == SLOT_W'(i))
                sel_byte = regs_flat[i*8 +: 8];
    end

    assign trap_en = regs_flat[TRAP_SLOT*8];
    assign onchip  = idx_take || data_take;
    assign ext_req = strobe && !onchip;
    assign smi_trap = strobe && win_hit && trap_en;

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (data_take)
                io_rdata[DATA_LANE*8 +: 8] = sel_byte;
            else
                io_rdata = ext_rdata;
        end
    end

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
    import cfg_port_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [15:2]           io_addr,
    input logic [3:0]            io_be,
    input logic                  io_rd,
    input logic                  io_wr,
    input logic [31:0]           io_wdata,
    input logic [31:0]           io_rdata,
    input logic [31:0]           ext_rdata,
    input logic                  ext_req,
    input logic                  smi_trap,
    input logic                  armed,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    logic a22, a23, stb;
    assign a22 = (io_addr == 14'h0008) && (io_be == 4'b0100);
    assign a23 = (io_addr == 14'h0008) && (io_be == 4'b1000);
    assign stb = io_rd || io_wr;

    p_idx_absorb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && a22 && idx_valid(io_wdata[23:16])) |-> !ext_req);
    p_idx_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && a22 && idx_valid(io_wdata[23:16])) |=> armed);
    p_bad_idx_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && a22 && !idx_valid(io_wdata[23:16])) |-> ext_req);
    p_bad_idx_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && a22 && !idx_valid(io_wdata[23:16])) |=> !armed);
    p_idx_read_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && a22) |-> ext_req);
    p_unarmed_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && a23 && !armed) |-> ext_req);
    p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && a23 && armed) |=> $stable(regs_flat));
    p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && a23) |=> !armed);
    p_ext_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && ext_req) |-> (io_rdata == ext_rdata));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> (!ext_req && !smi_trap && io_rdata == 32'h0));
    p_trap_fwd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        smi_trap |-> (stb && ext_req));

endmodule

bind cfg_port_ctrl cfg_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_be    (io_be),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .ext_rdata(ext_rdata),
    .ext_req  (ext_req),
    .smi_trap (smi_trap),
    .armed    (armed),
    .regs_flat(regs_flat)
);

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:2] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [31:0] ext_rdata = '0;
    logic        ext_req;
    logic        smi_trap;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model state
    logic [7:0] m_reg [18];
    bit         m_armed;
    int         m_slot;

    always #5 clk = ~clk;

    cfg_port_ctrl u_cfg_port_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ext_rdata(ext_rdata), .ext_req(ext_req), .smi_trap(smi_trap)
    );

    function automatic bit valid_idx(input int v);
        return (v >= 'hC0 && v <= 'hCF) || v == 'hFE || v == 'hFF;
    endfunction

    function automatic int slot_of(input int v);
        if (v <= 'hCF) return v - 'hC0;
        return 16 + v - 'hFE;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive, compare with model, then advance model
    task automatic access(input bit rd, input bit wr, input logic [15:0] a,
                          input logic [3:0] be, input logic [31:0] wd,
                          input string tag);
        bit a22, a23, onchip, trap, exp_ext;
        int wv;
        logic [31:0] exp_rd;
        @(negedge clk);
        cyc++;
        io_rd = rd; io_wr = wr; io_addr = a[15:2]; io_be = be; io_wdata = wd;
        ext_rdata = 32'h5A000000 ^ (cyc * 32'h00010203);
        #1;
        a22 = (a[15:2] == 14'h0008) && (be == 4'b0100);
        a23 = (a[15:2] == 14'h0008) && (be == 4'b1000);
        wv  = int'(wd[23:16]);
        onchip = (wr && a22 && valid_idx(wv)) || ((rd || wr) && a23 && m_armed);
        exp_ext = (rd || wr) && !onchip;
        exp_rd = 32'h0;
        if (rd) exp_rd = onchip ? {m_reg[m_slot], 24'h0} : ext_rdata;
        trap = 1'b0;
        for (int l = 0; l < 4; l++) begin
            int ba;
            ba = int'({a[15:2], 2'b00}) + l;
            if (be[l] && ba >= 'h3B0 && ba <= 'h3DF) trap = 1'b1;
        end
        trap = trap && (rd || wr) && m_reg[1][0];
        check(tag, "ext_req", {31'h0, ext_req}, {31'h0, exp_ext});
        check(tag, "smi_trap", {31'h0, smi_trap}, {31'h0, trap});
        check(tag, "io_rdata", io_rdata, exp_rd);
        if (wr && a22) begin
            if (valid_idx(wv)) begin m_armed = 1'b1; m_slot = slot_of(wv); end
            else m_armed = 1'b0;
        end
        if ((rd || wr) && a23 && m_armed) begin
            if (wr) m_reg[m_slot] = wd[31:24];
            m_armed = 1'b0;
        end
    endtask

    task automatic idle(input string tag);
        access(1'b0, 1'b0, 16'h0000, 4'b0000, 32'h0, tag);
    endtask
    task automatic set_idx(input int v, input string tag);
        access(1'b0, 1'b1, 16'h0020, 4'b0100, {8'h00, 8'(v), 16'h0}, tag);
    endtask
    task automatic dwr(input logic [7:0] v, input string tag);
        access(1'b0, 1'b1, 16'h0020, 4'b1000, {v, 24'h0}, tag);
    endtask
    task automatic drd(input string tag);
        access(1'b1, 1'b0, 16'h0020, 4'b1000, 32'h0, tag);
    endtask

    function automatic int nth_idx(input int i);
        return (i < 16) ? ('hC0 + i) : ('hFE + i - 16);
    endfunction

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 18; i++) m_reg[i] = 8'h00;
        m_armed = 1'b0; m_slot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle("R10 idle after reset");
        // R10: every register reads 00h after reset; first data read unarmed
        drd("R10 unarmed after reset");
        for (int i = 0; i < 18; i++) begin
            set_idx(nth_idx(i), "R10 arm");
            drd("R10 reset value");
        end
        // R2/R5/R6: fill and read back
        for (int i = 0; i < 18; i++) begin
            set_idx(nth_idx(i), "R2 arm");
            dwr(8'(8'h3C + i * 7) & 8'hFE, "R5 write");
        end
        for (int i = 0; i < 18; i++) begin
            set_idx(nth_idx(i), "R2 arm");
            drd("R6 readback");
        end
        // R7: unarmed data accesses go external, regs untouched
        dwr(8'hAA, "R7 unarmed write");
        drd("R7 unarmed read");
        set_idx('hC5, "R2 arm"); drd("R7 reg unchanged");
        // R3: invalid indices
        set_idx('h00, "R3 bad index");
        set_idx('hBF, "R3 bad index");
        set_idx('hD0, "R3 bad index");
        set_idx('hFD, "R3 bad index");
        set_idx('hC3, "R2 arm"); set_idx('h22, "R3 reject disarms");
        dwr(8'h11, "R3 data after reject");
        set_idx('hC3, "R2 arm"); drd("R3 regs unchanged");
        // R4: index read external and does not disarm
        set_idx('hCF, "R2 arm");
        access(1'b1, 1'b0, 16'h0020, 4'b0100, 32'h0, "R4 index read");
        drd("R4 still armed");
        // R8: one-shot
        set_idx('hFE, "R2 arm"); dwr(8'h77, "R8 first write"); dwr(8'h99, "R8 second write external");
        set_idx('hFF, "R2 arm"); drd("R8 first read"); drd("R8 second read external");
        set_idx('hFE, "R2 rearm"); set_idx('hC7, "R2 rearm"); drd("R2 rearm selects latest");
        // R1: lane decoding
        access(1'b0, 1'b1, 16'h0020, 4'b1100, 32'h00C40000, "R1 wide index write");
        drd("R1 not armed by wide write");
        set_idx('hC4, "R2 arm");
        access(1'b0, 1'b1, 16'h0020, 4'b1111, 32'hEEC40000, "R1 dword to ports");
        access(1'b1, 1'b0, 16'h0020, 4'b1100, 32'h0, "R1 word read");
        drd("R1 still armed");
        access(1'b0, 1'b1, 16'h0024, 4'b0100, 32'h00C00000, "R1 other dword");
        drd("R1 other dword no arm");
        // R9: general external traffic
        access(1'b1, 1'b0, 16'h0080, 4'b1111, 32'h0, "R9 external read");
        access(1'b0, 1'b1, 16'h1234, 4'b0011, 32'hDEADBEEF, "R9 external write");
        idle("R9 idle");
        // R11: trap disabled, then enabled, then disabled
        access(1'b1, 1'b0, 16'h03C0, 4'b1111, 32'h0, "R11 trap disabled");
        set_idx('hC1, "R2 arm"); dwr(8'h01, "R11 enable trap");
        access(1'b1, 1'b0, 16'h03B0, 4'b0001, 32'h0, "R11 window low edge");
        access(1'b0, 1'b1, 16'h03DC, 4'b1000, 32'h0, "R11 window high edge");
        access(1'b1, 1'b0, 16'h03AC, 4'b1000, 32'h0, "R11 below window");
        access(1'b1, 1'b0, 16'h03E0, 4'b0001, 32'h0, "R11 above window");
        access(1'b0, 1'b1, 16'h03D0, 4'b0110, 32'h1, "R11 inside window");
        idle("R11 no strobe");
        set_idx('hC1, "R2 arm"); dwr(8'h00, "R11 disable trap");
        access(1'b1, 1'b0, 16'h03C0, 4'b1111, 32'h0, "R11 disabled again");
        for (int i = 0; i < 18; i++) begin
            set_idx(nth_idx(i), "R2 arm");
            drd("R6 final readback");
        end
        idle("R9 end idle");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule